// File: doc/BRIEF.md
# Security Controller Interrupt Register Bank

This block is a small register bank that only secure bus accesses can reach. It serves a set of external master security controllers. Each controller reports a level-sensitive status line. The bank keeps those lines in a status register and merges them, through an enable register, into one combined interrupt. The bank also holds a non-secure configuration register whose upper field is driven straight onto one output wire per controller. A write to the clear register does not change the local status. Instead it sends a one-cycle clear pulse to each controller selected by the written data.

Each controller owns one bit, at position n+16, in the status, clear and non-secure words. The number of controllers is the parameter `N_CTRL` (default 4, at most 16). Software uses four word-aligned registers:

| Offset | Register | Access |
|--------|----------|--------|
| 0x0 | status | read-only |
| 0x4 | enable | read/write |
| 0x8 | clear | write-only |
| 0xC | non-secure control | read/write |

Read data is registered and appears one cycle after the request.

Top module: `msc_irq_bank`

## Requirements
- R1: Status input n appears in bit n+16 of the status register at offset 0x0. Bits 15:0, and every bit above 16+N_CTRL-1, read as zero.
- R2: Each status bit follows the level of its input, one clock edge after the input is sampled. The bit sets while the input is high and clears while it is low.
- R3: `irq_o` is registered. It is high exactly when the status register AND the enable register is nonzero. It updates on the same edge that captures a new status input or an enable write.
- R4: The enable register at offset 0x4 holds all 32 written bits and reads them back unchanged.
- R5: A secure write to offset 0x8 drives `clr_o[n]` from bit n+16 of the write data, for exactly the one cycle after the write edge. The write leaves the status register unchanged, and a read of offset 0x8 returns zero.
- R6: The non-secure control register at offset 0xC reads back the last written 32-bit value. `ns_o[n]` equals its bit n+16 and changes only on a secure write to 0xC.
- R7: After a synchronous reset, the status, enable and non-secure registers are zero, and `irq_o`, `clr_o`, `ns_o` and `rd_data` are all low.
- R8: Writes to the status offset 0x0 have no effect.
- R9: An access with `req_secure` low reads zero and changes no register and no output.
- R10: An access to an offset that is not one of 0x0, 0x4, 0x8 or 0xC, including an offset that is not word-aligned, reads zero and has no write effect.
- R11: `rd_data` shows, one cycle after a read request, the register contents as they stood before that edge. It is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| sts_i | input | N_CTRL | Level status from each controller |
| rd_data | output | 32 | Registered read data |
| clr_o | output | N_CTRL | One-cycle clear pulse per controller |
| ns_o | output | N_CTRL | Non-secure configuration per controller |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every result of this block is due at the first rising edge after its cause. This covers a status capture, the recomputed interrupt, a clear pulse, a new `ns_o` value and read data. The bench drives each stimulus after a falling edge and samples all four outputs 1 ns after the next rising edge. At that point it compares them with a model that it updates in the same step. Read expectations use the model state from before the step, because the read mux sees register contents before the edge. Clear pulses are expected to return to zero at the following sample.

// File: rtl/mscb_pkg.sv
package mscb_pkg;
  localparam int unsigned MSCB_DW      = 32;
  localparam int unsigned MSCB_FLD_LSB = 16;
  localparam int unsigned MSCB_MAX_CTL = 16;

  localparam int unsigned OFF_STAT = 32'h0;
  localparam int unsigned OFF_EN   = 32'h4;
  localparam int unsigned OFF_CLR  = 32'h8;
  localparam int unsigned OFF_NS   = 32'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_EN,
    SEL_CLR,
    SEL_NS
  } mscb_sel_e;
endpackage

// File: rtl/mscb_decode.sv
module mscb_decode
  import mscb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  output mscb_sel_e         sel,
  output logic              wr_en,
  output logic              rd_en
);
  logic granted;

  // Only valid secure accesses reach the registers.
  assign granted = req_valid && req_secure;
  assign wr_en   = granted && req_write;
  assign rd_en   = granted && !req_write;

  always_comb begin
    sel = SEL_NONE;
    if (granted) begin
      if (req_addr == ADDR_W'(OFF_STAT))     sel = SEL_STAT;
      else if (req_addr == ADDR_W'(OFF_EN))  sel = SEL_EN;
      else if (req_addr == ADDR_W'(OFF_CLR)) sel = SEL_CLR;
      else if (req_addr == ADDR_W'(OFF_NS))  sel = SEL_NS;
    end
  end
endmodule

// File: rtl/mscb_status.sv
module mscb_status
  import mscb_pkg::*;
#(
  parameter int unsigned N_CTRL = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CTRL-1:0] sts_i,
  input  logic [N_CTRL-1:0] en_fld_d,
  output logic [N_CTRL-1:0] stat_q,
  output logic              irq_o
);
  // The status register follows the input levels.
  // The interrupt is computed from next-state values so that it is aligned with them.
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= sts_i;
      irq_o  <= |(sts_i & en_fld_d);
    end
  end
endmodule

// File: rtl/mscb_ctrl_regs.sv
module mscb_ctrl_regs
  import mscb_pkg::*;
#(
  parameter int unsigned N_CTRL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  mscb_sel_e          sel,
  input  logic               wr_en,
  input  logic [MSCB_DW-1:0] wdata,
  output logic [MSCB_DW-1:0] en_q,
  output logic [MSCB_DW-1:0] en_d,
  output logic [MSCB_DW-1:0] ns_q,
  output logic [N_CTRL-1:0]  clr_o
);
  logic wr_enable, wr_ns, wr_clr;

  assign wr_enable = wr_en && (sel == SEL_EN);
  assign wr_ns     = wr_en && (sel == SEL_NS);
  assign wr_clr    = wr_en && (sel == SEL_CLR);
  assign en_d      = wr_enable ? wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ns_q  <= '0;
      clr_o <= '0;
    end else begin
      en_q  <= en_d;
      if (wr_ns) ns_q <= wdata;
      clr_o <= wr_clr ? wdata[MSCB_FLD_LSB +: N_CTRL] : '0;
    end
  end
endmodule

// File: rtl/mscb_rdmux.sv
module mscb_rdmux
  import mscb_pkg::*;
#(
  parameter int unsigned N_CTRL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  mscb_sel_e          sel,
  input  logic               rd_en,
  input  logic [N_CTRL-1:0]  stat_q,
  input  logic [MSCB_DW-1:0] en_q,
  input  logic [MSCB_DW-1:0] ns_q,
  output logic [MSCB_DW-1:0] rd_data
);
  logic [MSCB_DW-1:0] stat_word;
  logic [MSCB_DW-1:0] rd_next;

  always_comb begin
    stat_word = '0;
    stat_word[MSCB_FLD_LSB +: N_CTRL] = stat_q;
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_STAT: rd_next = stat_word;
        SEL_EN:   rd_next = en_q;
        SEL_NS:   rd_next = ns_q;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/msc_irq_bank.sv
module msc_irq_bank
  import mscb_pkg::*;
#(
  parameter int unsigned N_CTRL = 4,
  parameter int unsigned ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_secure,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [N_CTRL-1:0]  sts_i,
  output logic [31:0]        rd_data,
  output logic [N_CTRL-1:0]  clr_o,
  output logic [N_CTRL-1:0]  ns_o,
  output logic               irq_o
);
  mscb_sel_e          sel;
  logic               wr_en, rd_en;
  logic [MSCB_DW-1:0] en_q, en_d, ns_q;
  logic [N_CTRL-1:0]  stat_q;

  mscb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_secure(req_secure),
    .req_addr  (req_addr),
    .sel       (sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en)
  );

  mscb_ctrl_regs #(.N_CTRL(N_CTRL)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .wr_en(wr_en),
    .wdata(req_wdata),
    .en_q (en_q),
    .en_d (en_d),
    .ns_q (ns_q),
    .clr_o(clr_o)
  );

  mscb_status #(.N_CTRL(N_CTRL)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .sts_i   (sts_i),
    .en_fld_d(en_d[MSCB_FLD_LSB +: N_CTRL]),
    .stat_q  (stat_q),
    .irq_o   (irq_o)
  );

  mscb_rdmux #(.N_CTRL(N_CTRL)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .rd_en  (rd_en),
    .stat_q (stat_q),
    .en_q   (en_q),
    .ns_q   (ns_q),
    .rd_data(rd_data)
  );

  assign ns_o = ns_q[MSCB_FLD_LSB +: N_CTRL];
endmodule

// File: rtl/mscb_chk.sv
module mscb_chk
  import mscb_pkg::*;
#(
  parameter int unsigned N_CTRL = 4,
  parameter int unsigned ADDR_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic               req_secure,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [N_CTRL-1:0]  sts_i,
  input logic [31:0]        rd_data,
  input logic [N_CTRL-1:0]  clr_o,
  input logic [N_CTRL-1:0]  ns_o,
  input logic               irq_o,
  input logic [N_CTRL-1:0]  stat_q,
  input logic [31:0]        en_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic sec_wr_clr, sec_wr_ns, rd_clr, nonsec;
  assign sec_wr_clr = req_valid && req_write && req_secure && (req_addr == ADDR_W'(OFF_CLR));
  assign sec_wr_ns  = req_valid && req_write && req_secure && (req_addr == ADDR_W'(OFF_NS));
  assign rd_clr     = req_valid && !req_write && (req_addr == ADDR_W'(OFF_CLR));
  assign nonsec     = req_valid && !req_secure;

  // R2: status register tracks the input sampled one edge earlier
  p_stat_follow_r2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    stat_q == $past(sts_i));

  // R3: combined interrupt agrees with the stored status and enable
  p_irq_combine_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(stat_q & en_q[MSCB_FLD_LSB +: N_CTRL]));

  // R5: a clear pulse only follows a secure clear write
  p_clr_cause_r5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (|clr_o) |-> $past(sec_wr_clr));

  // R5: the clear offset reads as zero
  p_clr_reads_zero_r5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(rd_clr) |-> (rd_data == '0));

  // R6: the non-secure outputs move only after a secure write to their register
  p_ns_hold_r6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(sec_wr_ns) |-> $stable(ns_o));

  // R9: non-secure accesses read zero and cause no clear pulse
  p_nonsec_quiet_r9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $past(nonsec) |-> (rd_data == '0 && clr_o == '0));
endmodule

bind msc_irq_bank mscb_chk #(.N_CTRL(N_CTRL), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_secure(req_secure),
  .req_addr  (req_addr),
  .sts_i     (sts_i),
  .rd_data   (rd_data),
  .clr_o     (clr_o),
  .ns_o      (ns_o),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .en_q      (en_q)
);

// File: tb/msc_irq_bank_tb_top.sv
`timescale 1ns/1ps
module msc_irq_bank_tb_top;
  localparam int N      = 4;
  localparam int AW     = 12;
  localparam int LSB    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [N-1:0]  sts_i = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  clr_o, ns_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;

  // model
  logic [31:0]  m_en = '0, m_ns = '0;
  logic [N-1:0] m_stat = '0;

  always #2 clk = ~clk;

  msc_irq_bank #(.N_CTRL(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .sts_i(sts_i), .rd_data(rd_data), .clr_o(clr_o), .ns_o(ns_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic s, logic [AW-1:0] a);
    logic [31:0] w = '0;
    if (!s) return '0;
    case (a)
      12'h000: w[LSB +: N] = m_stat;
      12'h004: w = m_en;
      12'h00C: w = m_ns;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic string rd_tag(logic s, logic [AW-1:0] a);
    if (!s) return "R11 R9";
    case (a)
      12'h000: return "R11 R1 R2 R8";
      12'h004: return "R11 R4";
      12'h008: return "R11 R5";
      12'h00C: return "R11 R6";
      default: return "R11 R10";
    endcase
  endfunction

  task automatic step(logic v, logic w, logic s, logic [AW-1:0] a,
                      logic [31:0] d, logic [N-1:0] st);
    logic [31:0] exp_rd;
    logic [N-1:0] exp_clr;
    @(negedge clk);
    req_valid = v; req_write = w; req_secure = s; req_addr = a;
    req_wdata = d; sts_i = st;
    @(posedge clk); #1;
    exp_rd  = (v && !w) ? model_rd(s, a) : '0;
    exp_clr = '0;
    if (v && w && s) begin
      if (a == 12'h004) m_en = d;
      if (a == 12'h00C) m_ns = d;
      if (a == 12'h008) exp_clr = d[LSB +: N];
    end
    m_stat = st;
    chk(rd_tag(s, a), rd_data, exp_rd);
    chk((v && !s) ? "R9 clr" : "R5 clr", 32'(clr_o), 32'(exp_clr));
    chk((v && !s) ? "R9 ns" : "R6 ns", 32'(ns_o), 32'(m_ns[LSB +: N]));
    chk("R3 irq", 32'(irq_o), 32'(|(m_stat & m_en[LSB +: N])));
  endtask

  task automatic idle(logic [N-1:0] st);
    step(1'b0, 1'b0, 1'b1, '0, '0, st);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] addr_set [5];
    int seed;
    seed = $urandom(32'd2024);
    addr_set[0] = 12'h000; addr_set[1] = 12'h004; addr_set[2] = 12'h008;
    addr_set[3] = 12'h00C; addr_set[4] = 12'h010;

    repeat (3) @(posedge clk);
    #1;
    chk("R7 rd", rd_data, '0);
    chk("R7 clr", 32'(clr_o), '0);
    chk("R7 ns", 32'(ns_o), '0);
    chk("R7 irq", 32'(irq_o), '0);
    @(negedge clk); rst = 1'b0;

    // R7: registers read zero after reset
    step(1, 0, 1, 12'h004, '0, '0);
    step(1, 0, 1, 12'h00C, '0, '0);
    step(1, 0, 1, 12'h000, '0, '0);

    // R1/R2: status capture and low bits zero
    step(1, 0, 1, 12'h000, '0, 4'b1010);
    step(1, 0, 1, 12'h000, '0, 4'b0101);
    idle(4'b0000);
    // R4: full 32-bit enable, R3 irq
    step(1, 1, 1, 12'h004, 32'hFFFF_FFFF, 4'b0000);
    step(1, 0, 1, 12'h004, '0, 4'b0100);
    step(1, 1, 1, 12'h004, 32'h0002_0000, 4'b0100);
    step(1, 1, 1, 12'h004, 32'h0004_0000, 4'b0100);
    // R8: status write ignored
    step(1, 1, 1, 12'h000, 32'hFFFF_FFFF, 4'b0100);
    step(1, 0, 1, 12'h000, '0, 4'b0100);
    // R5: clear pulse, status unchanged
    step(1, 1, 1, 12'h008, 32'h000F_0000, 4'b0100);
    idle(4'b0100);
    step(1, 0, 1, 12'h008, '0, 4'b0100);
    step(1, 0, 1, 12'h000, '0, 4'b0100);
    // R6: ns write and read
    step(1, 1, 1, 12'h00C, 32'hA5C3_5A3C, 4'b0100);
    step(1, 0, 1, 12'h00C, '0, 4'b0100);
    // R9: non-secure accesses
    step(1, 1, 0, 12'h00C, 32'h0000_0000, 4'b0100);
    step(1, 1, 0, 12'h004, 32'h0000_0000, 4'b0100);
    step(1, 1, 0, 12'h008, 32'hFFFF_FFFF, 4'b0100);
    step(1, 0, 0, 12'h004, '0, 4'b0100);
    // R10: unaligned and unmapped
    step(1, 1, 1, 12'h006, 32'h0000_0000, 4'b0100);
    step(1, 1, 1, 12'h00D, 32'h0000_0000, 4'b0100);
    step(1, 0, 1, 12'h006, '0, 4'b0100);
    step(1, 0, 1, 12'h010, '0, 4'b0100);
    step(1, 0, 1, 12'h004, '0, 4'b0100);

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 8 == 0) ? AW'($urandom) : addr_set[$urandom % 5];
      step(1'($urandom % 4 != 0), 1'($urandom), 1'($urandom % 6 != 0), a,
           $urandom, N'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule